// File: doc/BRIEF.md
# Scan-Hold Register Chain

This block is a row of state cells, each built from a multiplexed-input scan flip-flop with a hold register behind it. In normal operation the flip-flops capture the parallel functional inputs. In test operation they form a serial shift path from a single serial input to a single serial output. The parallel outputs that feed downstream combinational logic come only from the hold registers.

With the hold control low, the hold registers keep their contents while test values are shifted through the flip-flops. The downstream logic therefore sees a frozen state during the whole shift. When the hold control is raised for one clock edge, every hold register takes the flip-flop contents present before that edge. A complete new state reaches the logic in one step. This supports launching two state vectors in succession for delay testing.

Reset is synchronous and active high. It clears both the flip-flops and the hold registers.

Top module: `shd_chain`

## Requirements
- R1: A clock edge with `rst` high clears every scan flip-flop and every hold register to 0, so `pout` and `sout` read 0 afterwards.
- R2: `rst` takes priority over `tc`, `hold`, `din` and `sin` at that edge.
- R3: On an edge with `tc` low, scan flip-flop k loads `din[k]`.
- R4: On an edge with `tc` high, scan flip-flop 0 loads `sin` and scan flip-flop k loads the old value of flip-flop k-1. After W shift edges driven with bits b0 first through bW-1 last, flip-flop k holds b(W-1-k).
- R5: `sout` always equals the value of scan flip-flop W-1, which is the last cell. It is taken from the flip-flop side, not from the hold side.
- R6: On an edge with `hold` low, `pout` keeps its value, whatever `tc`, `din` and `sin` do.
- R7: On an edge with `hold` high, bit k of `pout` loads the value that scan flip-flop k held just before that edge.
- R8: Two states shifted in back to back, each followed by one hold-high edge, appear on `pout` as exactly those two states, in order. No partially shifted value ever appears on `pout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tc | input | 1 | 1 selects serial shift, 0 selects functional capture |
| hold | input | 1 | 1 lets the hold registers take the flip-flop state, 0 freezes them |
| din | input | WIDTH | Functional data inputs, one bit per cell |
| sin | input | 1 | Serial input into cell 0 |
| pout | output | WIDTH | Held outputs to the downstream logic |
| sout | output | 1 | Serial output from the last scan flip-flop |

## Verification
Every result is due one edge after its stimulus:
- A flip-flop update from `din` or `sin` shows on `sout` one edge later.
- A hold-high edge shows on `pout` one edge later, carrying the flip-flop state from before that edge.

The bench sets inputs at the falling edge and keeps a model of both register ranks, advanced once per rising edge. It compares `pout` and `sout` one time unit after each rising edge. So every check reads the value due from exactly the inputs of the preceding edge. The launch sequence also checks that `pout` stays constant throughout each shift.

// File: rtl/shd_pkg.sv
package shd_pkg;
  localparam int unsigned SHD_DEF_WIDTH = 8;
  typedef enum logic {
    MODE_FUNC  = 1'b0,
    MODE_SHIFT = 1'b1
  } shd_mode_e;
endpackage

// File: rtl/shd_scan_cell.sv
module shd_scan_cell
  import shd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tc,
  input  logic d,
  input  logic si,
  output logic q
);
  shd_mode_e mode;
  logic      nxt;

  always_comb begin
    mode = shd_mode_e'(tc);
    nxt  = (mode == MODE_SHIFT) ? si : d;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  // R3: functional capture
  p_func_capture_r3: assert property (@(posedge clk) disable iff (rst)
    !tc |=> q == $past(d));
  // R4: serial shift
  p_shift_capture_r4: assert property (@(posedge clk) disable iff (rst)
    tc |=> q == $past(si));
  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> q == 1'b0);
endmodule

// File: rtl/shd_hold_stage.sv
module shd_hold_stage (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (hold) q <= d;
  end

  // R6: frozen while hold low
  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !hold |=> $stable(q));
  // R7: takes pre-edge flip-flop value
  p_apply_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> q == $past(d));
  // R2
  p_reset_prio_r2: assert property (@(posedge clk)
    rst |=> q == 1'b0);
endmodule

// File: rtl/shd_cell.sv
module shd_cell (
  input  logic clk,
  input  logic rst,
  input  logic tc,
  input  logic hold,
  input  logic d,
  input  logic si,
  output logic ff_q,
  output logic hold_q
);
  shd_scan_cell u_scan (
    .clk (clk),
    .rst (rst),
    .tc  (tc),
    .d   (d),
    .si  (si),
    .q   (ff_q)
  );

  shd_hold_stage u_hold (
    .clk  (clk),
    .rst  (rst),
    .hold (hold),
    .d    (ff_q),
    .q    (hold_q)
  );
endmodule

// File: rtl/shd_chain.sv
module shd_chain
  import shd_pkg::*;
#(
  parameter int unsigned WIDTH = SHD_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tc,
  input  logic             hold,
  input  logic [WIDTH-1:0] din,
  input  logic             sin,
  output logic [WIDTH-1:0] pout,
  output logic             sout
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] ff_vec;
  logic [WIDTH-1:0] ser_in;

  assign ser_in[0] = sin;

  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_cell
      if (k > 0) begin : g_link
        assign ser_in[k] = ff_vec[k-1];
      end
      shd_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .tc     (tc),
        .hold   (hold),
        .d      (din[k]),
        .si     (ser_in[k]),
        .ff_q   (ff_vec[k]),
        .hold_q (pout[k])
      );
    end
  endgenerate

  assign sout = ff_vec[LAST];

  // R5: serial path keeps moving while held outputs are frozen
  p_serial_tap_r5: assert property (@(posedge clk) disable iff (rst)
    (tc && !hold) |=> (sout == $past(ff_vec[LAST-1 > 0 ? LAST-1 : 0]) || WIDTH == 1) && $stable(pout));
endmodule

// File: tb/tb_shd_chain.sv
module tb_shd_chain;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tc = 1'b0;
  logic         hold = 1'b0;
  logic [W-1:0] din = '0;
  logic         sin = 1'b0;
  logic [W-1:0] pout;
  logic         sout;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_ff = '0;
  logic [W-1:0] m_out = '0;
  bit done = 0;

  always #5 clk = ~clk;

  shd_chain #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .tc(tc), .hold(hold),
    .din(din), .sin(sin), .pout(pout), .sout(sout)
  );

  function automatic logic [W-1:0] ff_next(logic [W-1:0] cur, logic r, logic t,
                                           logic [W-1:0] d, logic s);
    if (r) return '0;
    if (t) return {cur[W-2:0], s};
    return d;
  endfunction

  function automatic logic [W-1:0] out_next(logic [W-1:0] cur, logic [W-1:0] ff,
                                            logic r, logic h);
    if (r) return '0;
    if (h) return ff;
    return cur;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, model the rising edge, check 1 unit after it
  task automatic step(logic r, logic t, logic h, logic [W-1:0] d, logic s, string req);
    logic [W-1:0] nf, no;
    @(negedge clk);
    rst = r; tc = t; hold = h; din = d; sin = s;
    no = out_next(m_out, m_ff, r, h);
    nf = ff_next(m_ff, r, t, d, s);
    @(posedge clk);
    #1;
    m_ff = nf; m_out = no;
    chk({req, " pout"}, pout, m_out);
    chk({req, " sout"}, {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, m_ff[W-1]});
  endtask

  // shift a full state (bit W-1 of v ends in cell W-1), checking pout is frozen (R6, R8)
  task automatic load_state(logic [W-1:0] v);
    logic [W-1:0] frozen;
    frozen = m_out;
    for (int i = W - 1; i >= 0; i--) begin
      step(1'b0, 1'b1, 1'b0, $urandom, v[i], "R4");
      chk("R8 frozen", pout, frozen);
    end
    chk("R4 loaded", m_ff, v);
  endtask

  initial begin
    logic [W-1:0] a, b;
    void'($urandom(32'd4242));
    // R1 reset state
    step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R1");
    chk("R1 pout zero", pout, '0);
    // R2 reset priority with all controls active
    step(1'b0, 1'b0, 1'b1, '1, 1'b1, "R3");
    step(1'b1, 1'b1, 1'b1, '1, 1'b1, "R2");
    chk("R2 cleared", pout, '0);
    // R3 functional capture then apply
    step(1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, "R7");
    chk("R7 applied", pout, 8'hA5);
    // R5 serial out moves while pout frozen
    for (int i = 0; i < W; i++) step(1'b0, 1'b1, 1'b0, '0, 1'b1, "R5");
    // R8 launch sequence, two states
    a = 8'hC3; b = 8'h5A;
    load_state(a);
    step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R7");
    chk("R8 first state", pout, a);
    load_state(b);
    step(1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, "R7");
    chk("R8 second state", pout, b);
    // R6 hold low ignores all activity
    for (int i = 0; i < 10; i++) step(1'b0, i[0], 1'b0, $urandom, $urandom, "R6");
    // random mix
    for (int i = 0; i < 400; i++)
      step(($urandom % 40) == 0, $urandom, $urandom, $urandom, $urandom, "R3/R4/R7");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule